// File: doc/BRIEF.md
# Data-buffer control-word write sequencer

This block sits between memory initialisation and training logic and a DDR4 load-reduced data buffer. It takes one high-level request at a time and turns it into the paged control-word writes the buffer needs. A request can do one of four things: set the buffer training mode, declare how many package ranks are fitted, program the receive-enable delay of one nibble of one rank, or fire a buffer command. Every accepted request first emits a page-select write that points the buffer at the right function space. Then it emits the target write. When that target lives outside page 0, a final page-select write returns the buffer to page 0, so the next request always starts from a known page.

Every write appears as a one-cycle strobe. The strobe carries the function space, the word number, eight data bits and a flag that says whether the word is 4-bit or 8-bit. After each write the sequencer holds off until the required gap has passed: tMRD after a page select, tMRC after a target write. `busy` is high while a request is in progress. `done` pulses once when it ends. A request whose arguments cannot be encoded produces no writes at all, and `done` pulses together with `err` instead.

Top module: `bcw_seq`

## Requirements
- R1: After a synchronous reset, `cw_stb`, `busy`, `done` and `err` are all low.
- R2: The first strobe of every accepted request is a page select: 8-bit (`cw_wide`=1), word 7, function-space field 0, data equal to the target's function space. `req_kind` uses these codes: 0 training mode, 1 rank presence, 2 receive-enable delay, 3 buffer command. The request is sampled on the clock edge where `req_valid` is high and `busy` is low, and the select strobe appears in the cycle after that edge.
- R3: For a training-mode request, `req_arg` 0..6 picks normal, MREP, DWL, HWL, MRD, MWD or HIW. The target write is 4-bit word 0xC in page 0, with data 0, 1, 4, 5, 6, 7 and 8 respectively.
- R4: For a rank-presence request, `req_arg` is the package-rank count. The target write is 4-bit word 0x7 in page 0, with data 4'b1110, 4'b1100, 4'b1000 and 4'b0000 for counts 1, 2, 3 and 4.
- R5: For a receive-enable delay request, the target write is 8-bit, in function space `req_rank`, with word 2 when `req_upper`=0 and word 3 when `req_upper`=1, and with data `req_arg`.
- R6: For a buffer-command request, the target write is 4-bit word 0x6 in page 0, with data `req_arg`. Valid codes are 0 DLL reset, 1 long ZQ calibration, 2 short ZQ calibration, 3 clear error status and 4 soft reset.
- R7: The next strobe after a page-select write comes exactly TMRD cycles later (default 8). When that select is the last write of a request, `done` comes TMRD cycles after it instead.
- R8: The next strobe after a target write comes exactly TMRC cycles later (default 16). When the target write is the last write of a request, `done` comes TMRC cycles after it instead.
- R9: When the target function space is not 0, a third strobe writes a page select with data 0. When the target function space is 0, no third strobe is issued.
- R10: The following requests are rejected: a training index above 6, a rank count outside 1..4, a delay above 63, a rank index of 4 or more, and a command code above 4. A rejected request issues no strobe, leaves `busy` low, and raises `done` and `err` together in the cycle after it is sampled.
- R11: `busy` goes high in the cycle of the first strobe and falls in the cycle where `done` pulses. A `req_valid` seen while `busy` is high is ignored and adds no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_kind | input | 2 | Request type (0 mode, 1 ranks, 2 delay, 3 command) |
| req_arg | input | 8 | Mode index, rank count, delay or command code |
| req_rank | input | 3 | Rank index for delay requests |
| req_upper | input | 1 | Nibble select for delay requests (1 = upper) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | With `done`: request rejected |
| cw_stb | output | 1 | Control-word write strobe |
| cw_fspace | output | 3 | Function space of the write |
| cw_word | output | 4 | Control-word number |
| cw_data | output | 8 | Write data |
| cw_wide | output | 1 | 1 = 8-bit word, 0 = 4-bit word |

## Verification
The assertions check some behaviours on every cycle. Every strobe is at least TMRD or TMRC after the previous strobe, depending on what that previous write was. Page-select writes always carry page field 0. Strobes occur only while `busy` is high. `done` never overlaps `busy`. An error never coincides with a strobe. A successful request never ends while the buffer is left outside page 0.

Other behaviours can only be shown by the bench's scenarios. These are the exact encodings of each training mode, rank count and command, the nibble-to-word mapping, the exact gaps rather than lower bounds, the rejection of each kind of invalid argument, and the dropping of a request presented while busy.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  localparam int FS_W   = 3;
  localparam int WORD_W = 4;
  localparam int DATA_W = 8;

  localparam logic [WORD_W-1:0] W_PAGE_SEL = 4'h7;
  localparam logic [WORD_W-1:0] W_CMD      = 4'h6;
  localparam logic [WORD_W-1:0] W_RANKS    = 4'h7;
  localparam logic [WORD_W-1:0] W_TRAIN    = 4'hC;
  localparam logic [WORD_W-1:0] W_RXEN_LO  = 4'h2;
  localparam logic [WORD_W-1:0] W_RXEN_HI  = 4'h3;

  typedef enum logic [1:0] {
    K_TRAIN = 2'd0,
    K_RANKS = 2'd1,
    K_RXEN  = 2'd2,
    K_CMD   = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic [FS_W-1:0]   fs;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] data;
    logic              wide;
  } cw_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_TGT  = 2'd2,
    ST_RST  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/bcw_req_decode.sv
module bcw_req_decode
  import bcw_pkg::*;
#(
  parameter int RANK_W    = 3,
  parameter int NUM_RANKS = 4,
  parameter int MAX_DELAY = 63,
  parameter int MAX_CMD   = 4,
  parameter int MAX_TRAIN = 6
) (
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] arg,
  input  logic [RANK_W-1:0] rank,
  input  logic              upper,
  output logic              ok,
  output cw_t               tgt
);

  localparam logic [DATA_W-1:0] DLY_LIM   = DATA_W'(MAX_DELAY);
  localparam logic [DATA_W-1:0] CMD_LIM   = DATA_W'(MAX_CMD);
  localparam logic [DATA_W-1:0] TRAIN_LIM = DATA_W'(MAX_TRAIN);
  localparam logic [RANK_W-1:0] RANK_LIM  = RANK_W'(NUM_RANKS);

  logic [3:0] rank_mask;

  // Absent ranks are flagged from the top bit downwards.
  always_comb begin
    rank_mask = 4'(5'b01111 << arg[2:0]);
  end

  always_comb begin
    ok  = 1'b0;
    tgt = '0;
    unique case (req_kind_e'(kind))
      K_TRAIN: begin
        ok       = (arg <= TRAIN_LIM);
        tgt.word = W_TRAIN;
        // Codes 2 and 3 are unused, so indices from 2 upwards skip by two.
        tgt.data = (arg < 8'd2) ? arg : arg + 8'd2;
      end
      K_RANKS: begin
        ok       = (arg >= 8'd1) && (arg <= 8'd4);
        tgt.word = W_RANKS;
        tgt.data = {4'b0, rank_mask};
      end
      K_RXEN: begin
        ok       = (arg <= DLY_LIM) && (rank < RANK_LIM);
        tgt.fs   = FS_W'(rank);
        tgt.word = upper ? W_RXEN_HI : W_RXEN_LO;
        tgt.data = arg;
        tgt.wide = 1'b1;
      end
      K_CMD: begin
        ok       = (arg <= CMD_LIM);
        tgt.word = W_CMD;
        tgt.data = arg;
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/bcw_gap_timer.sv
module bcw_gap_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/bcw_seq.sv
module bcw_seq
  import bcw_pkg::*;
#(
  parameter int TMRD      = 8,
  parameter int TMRC      = 16,
  parameter int RANK_W    = 3,
  parameter int NUM_RANKS = 4,
  parameter int MAX_DELAY = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [7:0]        req_arg,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              req_upper,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cw_stb,
  output logic [2:0]        cw_fspace,
  output logic [3:0]        cw_word,
  output logic [7:0]        cw_data,
  output logic              cw_wide
);

  localparam int GAP_MAX = (TMRC > TMRD) ? TMRC : TMRD;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(TMRD - 1);
  localparam logic [CNT_W-1:0] LD_MRC = CNT_W'(TMRC - 1);

  seq_state_e state;
  cw_t        tgt_q;
  cw_t        dec_tgt;
  logic       dec_ok;
  logic       tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic       take, reject, issue_sel, issue_tgt, issue_rst, finish;

  bcw_req_decode #(
    .RANK_W   (RANK_W),
    .NUM_RANKS(NUM_RANKS),
    .MAX_DELAY(MAX_DELAY)
  ) u_dec (
    .kind (req_kind),
    .arg  (req_arg),
    .rank (req_rank),
    .upper(req_upper),
    .ok   (dec_ok),
    .tgt  (dec_tgt)
  );

  bcw_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  always_comb begin
    take      = (state == ST_IDLE) && req_valid;
    issue_sel = take && dec_ok;
    reject    = take && !dec_ok;
    issue_tgt = (state == ST_SEL) && tmr_zero;
    issue_rst = (state == ST_TGT) && tmr_zero && (tgt_q.fs != '0);
    finish    = ((state == ST_TGT) && tmr_zero && (tgt_q.fs == '0)) ||
                ((state == ST_RST) && tmr_zero);
    tmr_load  = issue_sel || issue_tgt || issue_rst;
    tmr_val   = issue_tgt ? LD_MRC : LD_MRD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tgt_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      cw_stb    <= 1'b0;
      cw_fspace <= '0;
      cw_word   <= '0;
      cw_data   <= '0;
      cw_wide   <= 1'b0;
    end else begin
      cw_stb <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      if (reject) begin
        done <= 1'b1;
        err  <= 1'b1;
      end
      if (issue_sel) begin
        tgt_q     <= dec_tgt;
        busy      <= 1'b1;
        state     <= ST_SEL;
        cw_stb    <= 1'b1;
        cw_fspace <= '0;
        cw_word   <= W_PAGE_SEL;
        cw_data   <= DATA_W'(dec_tgt.fs);
        cw_wide   <= 1'b1;
      end
      if (issue_tgt) begin
        state     <= ST_TGT;
        cw_stb    <= 1'b1;
        cw_fspace <= tgt_q.fs;
        cw_word   <= tgt_q.word;
        cw_data   <= tgt_q.data;
        cw_wide   <= tgt_q.wide;
      end
      if (issue_rst) begin
        state     <= ST_RST;
        cw_stb    <= 1'b1;
        cw_fspace <= '0;
        cw_word   <= W_PAGE_SEL;
        cw_data   <= '0;
        cw_wide   <= 1'b1;
      end
      if (finish) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  localparam int SW = CNT_W + 1;
  localparam logic [SW-1:0] S_MAX = '1;
  localparam logic [SW-1:0] S_MRD = SW'(TMRD);
  localparam logic [SW-1:0] S_MRC = SW'(TMRC);

  logic [SW-1:0] since_stb;
  logic          prev_long;
  logic [7:0]    last_page;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_stb <= S_MAX;
      prev_long <= 1'b0;
      last_page <= '0;
    end else begin
      if (cw_stb) since_stb <= SW'(1);
      else if (since_stb != S_MAX) since_stb <= since_stb + 1'b1;
      if (cw_stb) prev_long <= !(cw_wide && (cw_word == W_PAGE_SEL));
      if (cw_stb && cw_wide && (cw_word == W_PAGE_SEL)) last_page <= cw_data;
    end
  end

  assert_gap_R7_R8: assert property (@(posedge clk) disable iff (rst)
    cw_stb |-> (since_stb >= (prev_long ? S_MRC : S_MRD)));

  assert_page_field_R2: assert property (@(posedge clk) disable iff (rst)
    (cw_stb && cw_wide && (cw_word == W_PAGE_SEL)) |-> (cw_fspace == '0 && cw_data < 8'd8));

  assert_stb_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
    cw_stb |-> busy);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !cw_stb));

  assert_page_home_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (last_page == 8'd0));

endmodule

// File: tb/bcw_seq_bench.sv
module bcw_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TMRD = 8;
  localparam int TMRC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_arg = '0;
  logic [2:0] req_rank = '0;
  logic       req_upper = 1'b0;
  logic       busy, done, err, cw_stb, cw_wide;
  logic [2:0] cw_fspace;
  logic [3:0] cw_word;
  logic [7:0] cw_data;

  int total = 0;
  int bad   = 0;

  int         n_log;
  int         l_k[8];
  logic [2:0] l_fs[8];
  logic [3:0] l_word[8];
  logic [7:0] l_data[8];
  logic       l_wide[8];
  int         done_k;
  logic       done_err;
  logic       busy_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcw_seq u_bcw_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .req_rank(req_rank), .req_upper(req_upper),
    .busy(busy), .done(done), .err(err), .cw_stb(cw_stb),
    .cw_fspace(cw_fspace), .cw_word(cw_word), .cw_data(cw_data), .cw_wide(cw_wide)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives one request and records every strobe with its edge index after acceptance.
  task automatic send(input logic [1:0] kind, input logic [7:0] arg,
                      input logic [2:0] rank, input logic upper, input bit intrude);
    n_log = 0; done_k = -1; done_err = 0; busy_ok = 1;
    @(negedge clk);
    req_kind = kind; req_arg = arg; req_rank = rank; req_upper = upper; req_valid = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude && k == 2) begin
        req_kind = 2'd3; req_arg = 8'd1; req_valid = 1'b1;
      end
      if (cw_stb && n_log < 8) begin
        l_k[n_log] = k; l_fs[n_log] = cw_fspace; l_word[n_log] = cw_word;
        l_data[n_log] = cw_data; l_wide[n_log] = cw_wide; n_log++;
      end
      if (done) begin
        done_k = k; done_err = err;
        if (busy) busy_ok = 0;
        break;
      end
      if (!busy) busy_ok = 0;
    end
    req_valid = 1'b0;
    chk(done_k >= 0, "watchdog R11", done_k, 0);
  endtask

  task automatic expect_ok(input string tag, input logic [2:0] fs, input logic [3:0] word,
                           input logic [7:0] data, input logic wide);
    bit rest = (fs != 0);
    chk(n_log == (rest ? 3 : 2), "R9 strobe count", n_log, rest ? 3 : 2);
    if (n_log < 2) return;
    chk(l_wide[0] && l_word[0] == 4'h7 && l_fs[0] == 0 && l_data[0] == 8'(fs),
        "R2 page select", int'(l_data[0]), int'(fs));
    chk(l_k[0] == 0, "R2 select timing", l_k[0], 0);
    chk(l_fs[1] == fs && l_word[1] == word && l_wide[1] == wide, {tag, " target addr"},
        int'(l_word[1]), int'(word));
    chk(l_data[1] == data, {tag, " target data"}, int'(l_data[1]), int'(data));
    chk(l_k[1] - l_k[0] == TMRD, "R7 select gap", l_k[1] - l_k[0], TMRD);
    if (rest && n_log == 3) begin
      chk(l_wide[2] && l_word[2] == 4'h7 && l_data[2] == 0, "R9 page restore",
          int'(l_data[2]), 0);
      chk(l_k[2] - l_k[1] == TMRC, "R8 target gap", l_k[2] - l_k[1], TMRC);
      chk(done_k - l_k[2] == TMRD, "R7 restore gap", done_k - l_k[2], TMRD);
    end else begin
      chk(done_k - l_k[1] == TMRC, "R8 target gap", done_k - l_k[1], TMRC);
    end
    chk(!done_err && busy_ok, "R11 handshake", int'(done_err), 0);
  endtask

  task automatic expect_rej(input string tag);
    chk(n_log == 0, {tag, " R10 no strobes"}, n_log, 0);
    chk(done_k == 0 && done_err, {tag, " R10 err timing"}, done_k, 0);
  endtask

  task automatic t_reset;
    chk(!cw_stb && !busy && !done && !err, "R1 reset outputs",
        int'({cw_stb, busy, done, err}), 0);
  endtask

  task automatic t_train;
    for (int i = 0; i < 7; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'd0; 1: e = 8'd1; 2: e = 8'd4; 3: e = 8'd5;
        4: e = 8'd6; 5: e = 8'd7; default: e = 8'd8;
      endcase
      send(2'd0, 8'(i), 3'd0, 1'b0, 1'b0);
      expect_ok("R3", 3'd0, 4'hC, e, 1'b0);
    end
    send(2'd0, 8'd7, 3'd0, 1'b0, 1'b0);
    expect_rej("train idx 7");
  endtask

  task automatic t_ranks;
    for (int n = 1; n <= 4; n++) begin
      logic [7:0] e;
      case (n)
        1: e = 8'b1110; 2: e = 8'b1100; 3: e = 8'b1000; default: e = 8'b0000;
      endcase
      send(2'd1, 8'(n), 3'd0, 1'b0, 1'b0);
      expect_ok("R4", 3'd0, 4'h7, e, 1'b0);
    end
    send(2'd1, 8'd0, 3'd0, 1'b0, 1'b0);
    expect_rej("ranks 0");
    send(2'd1, 8'd5, 3'd0, 1'b0, 1'b0);
    expect_rej("ranks 5");
  endtask

  task automatic t_rxen;
    send(2'd2, 8'd0, 3'd0, 1'b0, 1'b0);
    expect_ok("R5", 3'd0, 4'h2, 8'd0, 1'b1);
    send(2'd2, 8'd63, 3'd3, 1'b1, 1'b0);
    expect_ok("R5", 3'd3, 4'h3, 8'd63, 1'b1);
    send(2'd2, 8'd17, 3'd2, 1'b0, 1'b0);
    expect_ok("R5", 3'd2, 4'h2, 8'd17, 1'b1);
    send(2'd2, 8'd64, 3'd1, 1'b0, 1'b0);
    expect_rej("delay 64");
    send(2'd2, 8'd5, 3'd4, 1'b1, 1'b0);
    expect_rej("rank 4");
  endtask

  task automatic t_cmd;
    for (int c = 0; c <= 4; c++) begin
      send(2'd3, 8'(c), 3'd0, 1'b0, 1'b0);
      expect_ok("R6", 3'd0, 4'h6, 8'(c), 1'b0);
    end
    send(2'd3, 8'd5, 3'd0, 1'b0, 1'b0);
    expect_rej("cmd 5");
  endtask

  task automatic t_busy_ignore;
    send(2'd2, 8'd9, 3'd1, 1'b1, 1'b1);
    expect_ok("R11 intruded", 3'd1, 4'h3, 8'd9, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && !cw_stb, "R11 dropped request", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_train();
    t_ranks();
    t_rxen();
    t_cmd();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule